// File: doc/BRIEF.md
# Banked Flash Concurrency and Write-Guard Controller

This block sits in front of a word-addressed flash array of four mega-words and answers two questions for every access: which bank and sector the address falls in, and whether the access may go ahead. The space is cut into four banks, numbered 0 to 3 from the bottom of the address range. The two outer banks carry small boot sectors at the very bottom and the very top of the space. The two inner banks hold only large sectors. One embedded program or erase may run at a time. While it runs, reads to the other three banks go straight to the array, and reads to the busy bank are steered to the status path.

Program and erase requests pass through a write guard before they start. A request is refused when a low-supply detect is raised, when another embedded operation is already running, when the write-protect pin is low and the target is one of the two lowest or two highest boot sectors, or when the target sector's persistent lock bit is set. A refusal is a one-cycle reject pulse and leaves every piece of state as it was. Lock bits are set one sector at a time and cleared all at once. Every response is registered and appears one clock after the request.

Top module: `fbank_guard`

## Requirements
- R1: Sector numbers are global and rise with address. Word addresses 0x000000–0x007FFF form eight 4K-word sectors, 0 to 7. Sectors 8 to 133 are 32K-word sectors, where sector = 7 + (address >> 15). Addresses 0x3F8000–0x3FFFFF form eight 4K-word sectors, 134 to 141.
- R2: Bank 0 covers sectors 0–22. Bank 1 covers 23–70. Bank 2 covers 71–118. Bank 3 covers 119–141. `rsp_bank` and `rsp_sector` report the request of the previous cycle, and `rsp_valid` is high in that cycle.
- R3: A read (kind 0) is served from the array (`rsp_status_sel`=0) when no embedded operation runs, or when it targets a bank other than the busy one.
- R4: A read to the bank holding the running embedded operation returns `rsp_status_sel`=1.
- R5: An accepted program (kind 1) or erase (kind 2) raises `emb_busy` and loads `emb_bank` one cycle after the request. `op_done` clears `emb_busy` one cycle later.
- R6: A program or erase request while `emb_busy` is high is rejected, and this includes the cycle in which `op_done` arrives.
- R7: While `wp_n` is low, program or erase to sectors 0, 1, 140 or 141 is rejected. Sectors 2 and 139 stay writable. With `wp_n` high, no sector is protected by the pin.
- R8: Kind 3 sets the lock bit of the addressed sector, and kind 4 clears all lock bits. Program or erase to a locked sector is rejected. The bits are cleared at reset.
- R9: While `low_vdd` is high, program, erase, lock and unlock-all requests are all rejected, and a refused lock request leaves the lock bits unchanged.
- R10: A rejection sets `rsp_reject` for exactly the one response cycle. It starts no operation and changes neither `emb_busy` nor `emb_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 read, 1 program, 2 erase, 3 lock sector, 4 unlock all |
| req_addr | input | 22 | Word address of the request |
| wp_n | input | 1 | Write-protect pin, low protects the outer boot sectors |
| low_vdd | input | 1 | Low-supply detect, high inhibits writes |
| op_done | input | 1 | Embedded operation finished |
| rsp_valid | output | 1 | Response fields below refer to the last request |
| rsp_bank | output | 2 | Bank index of the last request |
| rsp_sector | output | 8 | Global sector index of the last request |
| rsp_status_sel | output | 1 | 1 = read answered from status path |
| rsp_reject | output | 1 | One-cycle pulse: request refused |
| emb_busy | output | 1 | An embedded program or erase is running |
| emb_bank | output | 2 | Bank of the running operation |

## Verification
The hardest case to reach is the cycle in which `op_done` and a new program request arrive together. The request must still be refused, and the very next response must show the block idle. The bench starts an operation, then drives `op_done` and a fresh program in the same cycle. It checks the reject pulse and the cleared busy flag, and then issues a read to the formerly busy bank, which must now be served from the array. The refused lock under low supply is the other hard case. It is observed by a later erase of that sector, which must be accepted.

// File: rtl/fbank_pkg.sv
package fbank_pkg;
  localparam int SMALL_AW    = 12;
  localparam int LARGE_AW    = 15;
  localparam int BOOT_SECT   = 8;
  localparam int OUTER_LARGE = 15;
  localparam int INNER_LARGE = 48;
  localparam int WP_SECT     = 2;
  localparam int NBANK       = 4;

  localparam int OUTER_UNITS = 1 + OUTER_LARGE;
  localparam int UNITS       = 2 * OUTER_UNITS + 2 * INNER_LARGE;
  localparam int UNIT_W      = $clog2(UNITS);
  localparam int ADDR_W      = LARGE_AW + UNIT_W;
  localparam int SUB_W       = LARGE_AW - SMALL_AW;
  localparam int OUTER_SECT  = BOOT_SECT + OUTER_LARGE;
  localparam int SECT_TOTAL  = 2 * OUTER_SECT + 2 * INNER_LARGE;
  localparam int SECT_W      = $clog2(SECT_TOTAL);
  localparam int BANK_W      = $clog2(NBANK);

  typedef enum logic [2:0] {
    K_READ       = 3'd0,
    K_PROG       = 3'd1,
    K_ERASE      = 3'd2,
    K_LOCK       = 3'd3,
    K_UNLOCK_ALL = 3'd4
  } kind_t;
endpackage

// File: rtl/fbank_sector_map.sv
module fbank_sector_map
  import fbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [SECT_W-1:0] sector
);
  logic [UNIT_W-1:0] unit;
  logic [SUB_W-1:0]  sub;

  assign unit = addr[ADDR_W-1:LARGE_AW];
  assign sub  = addr[LARGE_AW-1:SMALL_AW];

  // R1: small sectors at both ends, large sectors in between
  always_comb begin
    if (unit == '0)
      sector = SECT_W'(sub);
    else if (unit == UNIT_W'(UNITS - 1))
      sector = SECT_W'(SECT_TOTAL - BOOT_SECT) + SECT_W'(sub);
    else
      sector = SECT_W'(BOOT_SECT - 1) + SECT_W'(unit);
  end

  // R2: bank boundaries on large-unit granularity
  always_comb begin
    if (unit < UNIT_W'(OUTER_UNITS))
      bank = BANK_W'(0);
    else if (unit < UNIT_W'(OUTER_UNITS + INNER_LARGE))
      bank = BANK_W'(1);
    else if (unit < UNIT_W'(OUTER_UNITS + 2 * INNER_LARGE))
      bank = BANK_W'(2);
    else
      bank = BANK_W'(3);
  end
endmodule

// File: rtl/fbank_lock_store.sv
module fbank_lock_store
  import fbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_all,
  input  logic [SECT_W-1:0] idx,
  input  logic              wp_n,
  output logic              locked,
  output logic              wp_hit
);
  logic [SECT_TOTAL-1:0] lock_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all)
      lock_q <= '0;
    else if (set_en)
      lock_q[idx] <= 1'b1;
  end

  assign locked = lock_q[idx];
  assign wp_hit = !wp_n && ((idx < SECT_W'(WP_SECT)) ||
                            (idx >= SECT_W'(SECT_TOTAL - WP_SECT)));

  // R8: a set request leaves the bit set on the next cycle
  a_r8_lock_sticks: assert property (@(posedge clk) disable iff (rst)
    set_en && !clr_all |=> locked || !$stable(idx));
endmodule

// File: rtl/fbank_guard.sv
module fbank_guard
  import fbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [21:0] req_addr,
  input  logic        wp_n,
  input  logic        low_vdd,
  input  logic        op_done,
  output logic        rsp_valid,
  output logic [1:0]  rsp_bank,
  output logic [7:0]  rsp_sector,
  output logic        rsp_status_sel,
  output logic        rsp_reject,
  output logic        emb_busy,
  output logic [1:0]  emb_bank
);
  kind_t             kind;
  logic [BANK_W-1:0] map_bank;
  logic [SECT_W-1:0] map_sector;
  logic              locked, wp_hit;
  logic              is_start, is_lockop, is_read;
  logic              start_block, start_ok, lock_ok, rej;

  assign kind = kind_t'(req_kind);

  fbank_sector_map u_map (
    .addr   (req_addr),
    .bank   (map_bank),
    .sector (map_sector)
  );

  assign is_read   = req_valid && (kind == K_READ);
  assign is_start  = req_valid && ((kind == K_PROG) || (kind == K_ERASE));
  assign is_lockop = req_valid && ((kind == K_LOCK) || (kind == K_UNLOCK_ALL));

  assign start_block = emb_busy || low_vdd || locked || wp_hit;
  assign start_ok    = is_start && !start_block;
  assign lock_ok     = is_lockop && !low_vdd;
  assign rej         = (is_start && start_block) || (is_lockop && low_vdd);

  fbank_lock_store u_lock (
    .clk     (clk),
    .rst     (rst),
    .set_en  (lock_ok && (kind == K_LOCK)),
    .clr_all (lock_ok && (kind == K_UNLOCK_ALL)),
    .idx     (map_sector),
    .wp_n    (wp_n),
    .locked  (locked),
    .wp_hit  (wp_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_bank       <= '0;
      rsp_sector     <= '0;
      rsp_status_sel <= 1'b0;
      rsp_reject     <= 1'b0;
      emb_busy       <= 1'b0;
      emb_bank       <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_reject     <= rej;
      rsp_status_sel <= is_read && emb_busy && (map_bank == emb_bank);
      if (req_valid) begin
        rsp_bank   <= map_bank;
        rsp_sector <= map_sector;
      end
      if (start_ok) begin
        emb_busy <= 1'b1;
        emb_bank <= map_bank;
      end else if (op_done) begin
        emb_busy <= 1'b0;
      end
    end
  end

  // R2: bank 0 holds exactly the lowest outer-bank sectors
  a_r2_bank_order: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_bank == 2'd0) == (rsp_sector < 8'(OUTER_SECT))));

  // R3: with nothing running, reads never go to status
  a_r3_idle_array: assert property (@(posedge clk) disable iff (rst)
    !emb_busy |=> !rsp_status_sel);

  // R4: status is only chosen for the bank that was busy
  a_r4_status_bank: assert property (@(posedge clk) disable iff (rst)
    rsp_status_sel |-> $past(emb_busy) && (rsp_bank == $past(emb_bank)));

  // R5: busy rises only after a start request, falls only after done
  a_r5_rise_start: assert property (@(posedge clk) disable iff (rst)
    $rose(emb_busy) |-> $past(req_valid) &&
      ($past(req_kind) == 3'd1 || $past(req_kind) == 3'd2));
  a_r5_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(emb_busy) |-> $past(op_done));

  // R6: a start while busy is refused
  a_r6_busy_reject: assert property (@(posedge clk) disable iff (rst)
    is_start && emb_busy |=> rsp_reject);

  // R7: pin protection of outer boot sectors
  a_r7_wp_reject: assert property (@(posedge clk) disable iff (rst)
    is_start && !wp_n && (map_sector < SECT_W'(WP_SECT)) |=> rsp_reject);

  // R9: low supply refuses every write-type request
  a_r9_lowv_reject: assert property (@(posedge clk) disable iff (rst)
    (is_start || is_lockop) && low_vdd |=> rsp_reject);

  // R10: a refused request never starts an operation
  a_r10_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_reject |-> !$rose(emb_busy) && $stable(emb_bank));
endmodule

// File: tb/fbank_guard_tb.sv
`timescale 1ns/1ps
module fbank_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [21:0] req_addr = '0;
  logic        wp_n = 1'b1;
  logic        low_vdd = 1'b0;
  logic        op_done = 1'b0;
  logic        rsp_valid, rsp_status_sel, rsp_reject, emb_busy;
  logic [1:0]  rsp_bank, emb_bank;
  logic [7:0]  rsp_sector;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fbank_guard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .wp_n(wp_n), .low_vdd(low_vdd), .op_done(op_done),
    .rsp_valid(rsp_valid), .rsp_bank(rsp_bank), .rsp_sector(rsp_sector),
    .rsp_status_sel(rsp_status_sel), .rsp_reject(rsp_reject),
    .emb_busy(emb_busy), .emb_bank(emb_bank)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample the registered response
  task automatic req(input logic [2:0] k, input logic [21:0] a, input logic done = 1'b0);
    req_valid = 1'b1; req_kind = k; req_addr = a; op_done = done;
    @(negedge clk);
    req_valid = 1'b0; op_done = 1'b0;
  endtask

  task automatic finish_op();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk("R5 done clears busy", emb_busy, 0);
  endtask

  task automatic t_reset();
    chk("R5 reset busy", emb_busy, 0);
    chk("R10 reset reject", rsp_reject, 0);
    chk("R2 reset valid", rsp_valid, 0);
  endtask

  task automatic map_one(input logic [21:0] a, input int eb, input int es);
    req(3'd0, a);
    chk("R2 valid", rsp_valid, 1);
    chk("R2 bank", rsp_bank, eb);
    chk("R1 sector", rsp_sector, es);
    chk("R3 idle read array", rsp_status_sel, 0);
  endtask

  task automatic t_map();
    map_one(22'h000000, 0, 0);
    map_one(22'h000FFF, 0, 0);
    map_one(22'h001000, 0, 1);
    map_one(22'h007FFF, 0, 7);
    map_one(22'h008000, 0, 8);
    map_one(22'h07FFFF, 0, 22);
    map_one(22'h080000, 1, 23);
    map_one(22'h1FFFFF, 1, 70);
    map_one(22'h200000, 2, 71);
    map_one(22'h37FFFF, 2, 118);
    map_one(22'h380000, 3, 119);
    map_one(22'h3F7FFF, 3, 133);
    map_one(22'h3F8000, 3, 134);
    map_one(22'h3FE000, 3, 140);
    map_one(22'h3FFFFF, 3, 141);
  endtask

  task automatic t_concurrency();
    req(3'd1, 22'h100000);
    chk("R5 start accepted", rsp_reject, 0);
    chk("R5 busy set", emb_busy, 1);
    chk("R5 busy bank", emb_bank, 1);
    req(3'd0, 22'h100010);
    chk("R4 busy bank status", rsp_status_sel, 1);
    req(3'd0, 22'h000000);
    chk("R3 bank0 array", rsp_status_sel, 0);
    req(3'd0, 22'h250000);
    chk("R3 bank2 array", rsp_status_sel, 0);
    req(3'd0, 22'h3FFFFF);
    chk("R3 bank3 array", rsp_status_sel, 0);
    req(3'd2, 22'h250000);
    chk("R6 second start reject", rsp_reject, 1);
    chk("R10 bank kept", emb_bank, 1);
    chk("R10 busy kept", emb_busy, 1);
    @(negedge clk);
    chk("R10 one-cycle pulse", rsp_reject, 0);
    req(3'd0, 22'h1FFFFF);
    chk("R4 status still", rsp_status_sel, 1);
    // start together with done: still refused, then idle
    req(3'd1, 22'h300000, 1'b1);
    chk("R6 start with done rejected", rsp_reject, 1);
    chk("R6 done same cycle clears", emb_busy, 0);
    req(3'd0, 22'h100000);
    chk("R3 freed bank array", rsp_status_sel, 0);
    chk("R10 no pulse on read", rsp_reject, 0);
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    req(3'd1, 22'h000000);
    chk("R7 sector0 reject", rsp_reject, 1);
    chk("R10 no start", emb_busy, 0);
    req(3'd2, 22'h001000);
    chk("R7 sector1 reject", rsp_reject, 1);
    req(3'd2, 22'h3FF000);
    chk("R7 sector141 reject", rsp_reject, 1);
    req(3'd1, 22'h3FE000);
    chk("R7 sector140 reject", rsp_reject, 1);
    req(3'd1, 22'h002000);
    chk("R7 sector2 accepted", rsp_reject, 0);
    chk("R7 sector2 busy", emb_busy, 1);
    finish_op();
    req(3'd2, 22'h3FD000);
    chk("R7 sector139 accepted", emb_busy, 1);
    chk("R7 sector139 bank", emb_bank, 3);
    finish_op();
    wp_n = 1'b1;
    req(3'd1, 22'h000000);
    chk("R7 wp high sector0 ok", rsp_reject, 0);
    finish_op();
  endtask

  task automatic t_lock();
    req(3'd3, 22'h200000);
    chk("R8 lock accepted", rsp_reject, 0);
    req(3'd2, 22'h200000);
    chk("R8 locked erase reject", rsp_reject, 1);
    chk("R8 locked no busy", emb_busy, 0);
    req(3'd2, 22'h208000);
    chk("R8 neighbour accepted", emb_busy, 1);
    finish_op();
    req(3'd4, 22'h000000);
    req(3'd2, 22'h200000);
    chk("R8 unlock all", rsp_reject, 0);
    chk("R8 unlocked busy", emb_busy, 1);
    finish_op();
  endtask

  task automatic t_lowv();
    low_vdd = 1'b1;
    req(3'd1, 22'h100000);
    chk("R9 program reject", rsp_reject, 1);
    chk("R9 no busy", emb_busy, 0);
    req(3'd3, 22'h158000);
    chk("R9 lock reject", rsp_reject, 1);
    req(3'd0, 22'h158000);
    chk("R9 read unaffected", rsp_reject, 0);
    low_vdd = 1'b0;
    req(3'd2, 22'h158000);
    chk("R9 refused lock had no effect", rsp_reject, 0);
    chk("R9 erase started", emb_busy, 1);
    finish_op();
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_concurrency();
    t_wp();
    t_lock();
    t_lowv();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule